// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two binary floating-point numbers in the 32-bit single-precision layout. Each word holds a sign bit, an 8-bit biased exponent (bias 127) and a 23-bit fraction. A normal number has the value (−1)^s × 1.f × 2^(e−127), with the leading one left out of the stored word. An exponent field of all ones encodes infinity when the fraction is zero and NaN when it is not. An exponent field of zero is read as zero.

When `in_valid` is high, the adder samples both operands, the subtract select and a two-bit rounding mode. One clock later it presents the rounded sum with `out_valid` high, together with three exception flags.

Inside, the block picks the operand with the larger magnitude and shifts the smaller significand right to align it. The shift keeps a guard bit, a round bit and a sticky bit that ORs every bit shifted out below them. It then adds or subtracts the aligned significands, normalises the result, rounds it and packs it. Results that fall below the normal range are flushed to zero.

Top module: `fp_add_single`

## Requirements
- R1: For normal operands, `result` is the correctly rounded sum of `op_a` and `op_b`, with the hidden leading one restored on unpack (1.0+1.0 = 0x40000000, 1.5+2.5 = 0x40800000).
- R2: When `sub` is high, the sign of `op_b` is inverted before the add (0x3E800000 − 0x3F800000 = 0xBF400000, the value −0.75).
- R3: Alignment keeps guard, round and sticky bits. Round-to-nearest-even goes up above the halfway point and breaks an exact tie toward an even fraction LSB.
- R4: `rmode` selects the rounding: 00 nearest-even, 01 toward zero, 10 toward +∞, 11 toward −∞.
- R5: An exact zero sum of opposite-signed operands gives +0, except in mode 11, where it gives −0. Two zeros of the same sign keep that sign.
- R6: If the rounded exponent reaches 255, `ovf` is set. The result is infinity in mode 00, in mode 10 for a positive sum and in mode 11 for a negative sum; otherwise it is the largest finite value of that sign (0x7F7FFFFF / 0xFF7FFFFF).
- R7: A nonzero result whose rounded exponent is 0 or below becomes a zero of the result's sign, and `unf` is set. Operands with a zero exponent field count as zero. No output has a zero exponent and a nonzero fraction.
- R8: A NaN operand, or infinities of opposite effective sign, gives 0x7FC00000 with `inv` set.
- R9: An infinity combined with a finite value, or with an infinity of the same effective sign, returns that infinity with no flag set.
- R10: `out_valid` is high exactly one cycle after `in_valid`, and results appear in input order.
- R11: While `rst_n` is low, `out_valid`, `result` and all flags are 0. No more than one flag is set at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub | input | 1 | 1 = compute op_a − op_b |
| rmode | input | 2 | Rounding mode (00 RNE, 01 RTZ, 10 +∞, 11 −∞) |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Rounded sum |
| ovf | output | 1 | Overflow flag |
| unf | output | 1 | Underflow (flushed) flag |
| inv | output | 1 | Invalid operation flag |

## Verification
The bench builds the adder with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths every expected value can be written as an exact single-precision word. At these widths the half-ULP tie at 2^-24 next to 1.0, the sticky bit that breaks that tie, and the carry out of rounding into the exponent are all easy to provoke. The defaults also make the 255 exponent ceiling and the 2^-126 floor reachable with operands close to those limits.

// File: rtl/fp_add_single.sv
module fp_add_single #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int DW    = 1 + EXP_W + FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          sub,
  input  logic [1:0]    rmode,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic          ovf,
  output logic          unf,
  output logic          inv
);
  localparam int MW = FRAC_W + 1;
  localparam int XW = MW + 3;
  localparam int EW = EXP_W + 2;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [DW-1:0] QNAN = {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}};

  logic sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [FRAC_W-1:0] fa, fb;
  assign sa = op_a[DW-1];
  assign sb = op_b[DW-1] ^ sub;
  assign ea = op_a[DW-2:FRAC_W];
  assign eb = op_b[DW-2:FRAC_W];
  assign fa = op_a[FRAC_W-1:0];
  assign fb = op_b[FRAC_W-1:0];

  logic za, zb, nan_any, inf_a, inf_b;
  assign za = (ea == '0);
  assign zb = (eb == '0);
  assign inf_a = (ea == EMAX) && (fa == '0);
  assign inf_b = (eb == EMAX) && (fb == '0);
  assign nan_any = ((ea == EMAX) && (fa != '0)) || ((eb == EMAX) && (fb != '0));

  logic [DW-2:0] key_a, key_b;
  logic [MW-1:0] ma, mb;
  assign key_a = za ? '0 : op_a[DW-2:0];
  assign key_b = zb ? '0 : op_b[DW-2:0];
  assign ma = za ? '0 : {1'b1, fa};
  assign mb = zb ? '0 : {1'b1, fb};

  logic swap, sL, sS, eff_sub;
  logic [EXP_W-1:0] eL, eS, diff;
  logic [MW-1:0] mL, mS;
  assign swap = key_b > key_a;
  assign sL = swap ? sb : sa;
  assign sS = swap ? sa : sb;
  assign eL = swap ? eb : ea;
  assign eS = swap ? ea : eb;
  assign mL = swap ? mb : ma;
  assign mS = swap ? ma : mb;
  assign diff = eL - eS;
  assign eff_sub = sL ^ sS;

  logic [XW-1:0] xs, al;
  logic stk;
  assign xs = {mS, 3'b000};
  always_comb begin
    if (int'(diff) >= XW) begin
      al  = '0;
      stk = |mS;
    end else begin
      al  = xs >> diff;
      stk = |(xs & ~({XW{1'b1}} << diff));
    end
    al[0] = al[0] | stk;
  end

  logic [XW:0] sum;
  logic zero_sum;
  assign sum = eff_sub ? ({1'b0, mL, 3'b000} - {1'b0, al})
                       : ({1'b0, mL, 3'b000} + {1'b0, al});
  assign zero_sum = (sum == '0);

  int hi;
  always_comb begin
    hi = 0;
    for (int i = 0; i < XW; i++)
      if (sum[i]) hi = i;
  end

  logic [EW-1:0] lz, exp_n, exp_r;
  logic [XW-1:0] nrm;
  assign lz = EW'(XW - 1 - hi);
  always_comb begin
    if (sum[XW]) begin
      nrm   = sum[XW:1];
      nrm[0] = sum[1] | sum[0];
      exp_n = {2'b00, eL} + EW'(1);
    end else begin
      nrm   = sum[XW-1:0] << lz;
      exp_n = {2'b00, eL} - lz;
    end
  end

  logic rs, g, r, st, lsb, inexact, inc;
  logic [MW:0] mr;
  logic [FRAC_W-1:0] frac_r;
  assign rs = zero_sum ? (eff_sub ? (rmode == 2'b11) : sL) : sL;
  assign lsb = nrm[3];
  assign g = nrm[2];
  assign r = nrm[1];
  assign st = nrm[0];
  assign inexact = g | r | st;
  always_comb begin
    case (rmode)
      2'b00:   inc = g & (r | st | lsb);
      2'b01:   inc = 1'b0;
      2'b10:   inc = inexact & ~rs;
      default: inc = inexact & rs;
    endcase
  end
  assign mr = {1'b0, nrm[XW-1:3]} + {{MW{1'b0}}, inc};
  assign exp_r = mr[MW] ? exp_n + EW'(1) : exp_n;
  assign frac_r = mr[MW] ? mr[FRAC_W:1] : mr[FRAC_W-1:0];

  logic to_inf, big, tiny;
  assign to_inf = (rmode == 2'b00) || (rmode == 2'b10 && !rs) || (rmode == 2'b11 && rs);
  assign big  = !exp_r[EW-1] && (exp_r >= {2'b00, EMAX});
  assign tiny = exp_r[EW-1] || (exp_r == '0);

  logic [DW-1:0] res_c;
  logic ovf_c, unf_c, inv_c;
  always_comb begin
    ovf_c = 1'b0;
    unf_c = 1'b0;
    inv_c = 1'b0;
    if (nan_any || (inf_a && inf_b && (sa != sb))) begin
      res_c = QNAN;
      inv_c = 1'b1;
    end else if (inf_a) begin
      res_c = {sa, EMAX, {FRAC_W{1'b0}}};
    end else if (inf_b) begin
      res_c = {sb, EMAX, {FRAC_W{1'b0}}};
    end else if (zero_sum) begin
      res_c = {rs, {(DW-1){1'b0}}};
    end else if (big) begin
      ovf_c = 1'b1;
      res_c = to_inf ? {rs, EMAX, {FRAC_W{1'b0}}} : {rs, EMAX - 1'b1, {FRAC_W{1'b1}}};
    end else if (tiny) begin
      unf_c = 1'b1;
      res_c = {rs, {(DW-1){1'b0}}};
    end else begin
      res_c = {rs, exp_r[EXP_W-1:0], frac_r};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
      inv       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_c;
        ovf    <= ovf_c;
        unf    <= unf_c;
        inv    <= inv_c;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_nan_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && inv |-> result == QNAN);
  a_r7_flush_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && unf |-> result[DW-2:0] == '0);
  a_r7_no_denormal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(result[DW-2:FRAC_W] == '0 && result[FRAC_W-1:0] != '0));
  a_r6_ovf_shape: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ovf |-> (result[DW-2:FRAC_W] == EMAX && result[FRAC_W-1:0] == '0) ||
                         (result[DW-2:FRAC_W] == EMAX - 1'b1 && &result[FRAC_W-1:0]));
  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf, unf, inv}));
endmodule

// File: tb/fp_add_single_test.sv
module fp_add_single_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic sub = 1'b0;
  logic [1:0] rmode = 2'b00;
  logic out_valid, ovf, unf, inv;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [34:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_add_single uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub(sub), .rmode(rmode), .out_valid(out_valid), .result(result),
    .ovf(ovf), .unf(unf), .inv(inv)
  );

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h/%b expected=%h/%b", tag, act[34:3], act[2:0], expv[34:3], expv[2:0]);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic s,
                      input logic [1:0] rm, input logic [31:0] r, input logic [2:0] fl,
                      input string tag);
    @(negedge clk);
    op_a = a; op_b = b; sub = s; rmode = rm; in_valid = 1'b1;
    exp_q.push_back({r, fl});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R10 out_valid with nothing pending actual=1 expected=0");
      end else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {result, ovf, unf, inv}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {out_valid, result, ovf, unf}, 35'd0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R1 plain sums
    send(32'h3F800000, 32'h3F800000, 0, 2'b00, 32'h40000000, 3'b000, "R1 1+1");
    send(32'h3FC00000, 32'h40200000, 0, 2'b00, 32'h40800000, 3'b000, "R1 1.5+2.5");
    send(32'h3FC00000, 32'h3FC00000, 0, 2'b00, 32'h40400000, 3'b000, "R1 1.5+1.5");
    // R2 subtract select
    send(32'h3E800000, 32'h3F800000, 1, 2'b00, 32'hBF400000, 3'b000, "R2 0.25-1 = -0.75");
    send(32'h3F800000, 32'h3F7FFFFF, 1, 2'b00, 32'h33800000, 3'b000, "R2 cancellation to 2^-24");
    // R3 ties and sticky
    send(32'h3F800000, 32'h33800000, 0, 2'b00, 32'h3F800000, 3'b000, "R3 tie to even stays");
    send(32'h3F800001, 32'h33800000, 0, 2'b00, 32'h3F800002, 3'b000, "R3 tie to even rounds up");
    send(32'h3F800000, 32'h33800001, 0, 2'b00, 32'h3F800001, 3'b000, "R3 sticky breaks tie");
    send(32'h3FFFFFFF, 32'h33800000, 0, 2'b00, 32'h40000000, 3'b000, "R3 round carry into exponent");
    // R4 modes
    send(32'h3F800000, 32'h33800000, 0, 2'b01, 32'h3F800000, 3'b000, "R4 toward zero");
    send(32'h3F800000, 32'h33800000, 0, 2'b10, 32'h3F800001, 3'b000, "R4 toward +inf");
    send(32'h3F800000, 32'h33800000, 0, 2'b11, 32'h3F800000, 3'b000, "R4 toward -inf positive");
    send(32'hBF800000, 32'hB3800000, 0, 2'b11, 32'hBF800001, 3'b000, "R4 toward -inf negative");
    send(32'hBF800000, 32'hB3800000, 0, 2'b10, 32'hBF800000, 3'b000, "R4 toward +inf negative");
    // R5 zero signs
    send(32'h3F800000, 32'h3F800000, 1, 2'b00, 32'h00000000, 3'b000, "R5 x-x nearest");
    send(32'h3F800000, 32'h3F800000, 1, 2'b11, 32'h80000000, 3'b000, "R5 x-x toward -inf");
    send(32'h80000000, 32'h80000000, 0, 2'b00, 32'h80000000, 3'b000, "R5 -0 + -0");
    // R6 overflow
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 2'b00, 32'h7F800000, 3'b100, "R6 nearest to inf");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 2'b01, 32'h7F7FFFFF, 3'b100, "R6 toward zero max");
    send(32'h7F7FFFFF, 32'h7F7FFFFF, 0, 2'b11, 32'h7F7FFFFF, 3'b100, "R6 toward -inf positive max");
    send(32'hFF7FFFFF, 32'hFF7FFFFF, 0, 2'b11, 32'hFF800000, 3'b100, "R6 toward -inf negative inf");
    // R7 underflow and zero-exponent inputs
    send(32'h00800000, 32'h00C00000, 1, 2'b00, 32'h80000000, 3'b010, "R7 flush to -0");
    send(32'h00000001, 32'h3F800000, 0, 2'b10, 32'h3F800000, 3'b000, "R7 denormal operand as zero");
    // R8 invalid
    send(32'h7F800000, 32'h7F800000, 1, 2'b00, 32'h7FC00000, 3'b001, "R8 inf-inf");
    send(32'h7F800000, 32'hFF800000, 0, 2'b00, 32'h7FC00000, 3'b001, "R8 inf+-inf");
    send(32'h7F800001, 32'h00000000, 0, 2'b00, 32'h7FC00000, 3'b001, "R8 nan operand");
    // R9 infinities
    send(32'h7F800000, 32'h3F800000, 0, 2'b00, 32'h7F800000, 3'b000, "R9 inf+1");
    send(32'h3F800000, 32'h7F800000, 1, 2'b00, 32'hFF800000, 3'b000, "R9 1-inf");
    send(32'hFF800000, 32'hFF800000, 0, 2'b00, 32'hFF800000, 3'b000, "R9 -inf+-inf");
    idle(3);
    check("R10 idle no valid", {34'd0, out_valid}, 35'd0);

    // R10 single-shot latency
    send(32'h3F800000, 32'h3F800000, 0, 2'b00, 32'h40000000, 3'b000, "R10 single op value");
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 valid after one cycle", {34'd0, out_valid}, 35'd1);
    idle(3);
    check("R10 queue drained", 35'(exp_q.size()), 35'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule